// File: doc/BRIEF.md
# Snooping victim cache bus agent

This block is a passive, direct-mapped line store that sits on a shared, pipelined, snoop-based processor bus. It never starts a transaction of its own. It watches every request on the bus. When another agent writes back an evicted line, the block copies that line into its storage. A later full-line read from another agent may hit that line. The block then claims the snoop with a modified-hit response and supplies the four data beats itself, as a cache-to-cache transfer. The memory side absorbs the same beats. Read-with-invalidate traffic to a held line drops that line.

The bus is reduced to plain signals: a request strobe with address, kind and requester id, a snoop strobe, a modified-hit output, a target-ready strobe, and a data path with data-ready and data-busy. Requests are paired with their snoop and response phases through an in-order queue. This allows several transactions to be outstanding at the same time. Every decision about a transaction is taken from the storage state in its request cycle.

Top module: `victim_snoop_agent`

## Requirements
- R1: After reset the store holds no valid line, `snp_hitm`, `out_drdy` and `out_dbsy` are low, and the first read of any address misses.
- R2: A full-line write-back (kind 2) from another agent sets the tag and valid bit of its entry in the request cycle. Its four data beats, taken from `bus_data_in` while `bus_drdy_in` is high, replace the entry's data.
- R3: A full-line read (kind 0) from another agent that matches a valid entry raises `snp_hitm` in the cycle its own `snp_strobe` is high, and in no other snoop cycle.
- R4: For a hit read, the block drives the line on the four cycles that follow the cycle in which `bus_trdy` is high for that read. On each of those cycles `out_drdy` and `out_dbsy` are both high, and both fall after the fourth beat. They are never high while `bus_drdy_in` is high.
- R5: A read that misses leaves `snp_hitm` low and drives no beat; the memory side supplies the data.
- R6: A read-with-invalidate, either kind 4 (no data) or kind 5 (full line), from another agent clears the valid bit of a matching entry and never raises `snp_hitm`.
- R7: Partial reads (kind 1), partial writes (kind 3) and every transaction whose requester id equals `AGENT_ID` leave the store unchanged and never raise `snp_hitm`.
- R8: At least `QDEPTH` transactions may be outstanding. Snoop and response strobes pair with requests in request order. A read issued after a write-back to the same line hits and returns the written-back data. A read issued before a write-back to the same index returns the old line.
- R9: The entry index is address bits [IW+4:5], with IW = log2(CAP_BYTES/32), and the tag is bits [35:IW+5]. A write-back to an index held under another tag displaces that line.
- R10: Beat k of a line transaction carries the 8-byte chunk numbered k XOR addr[4:3], both when the block fills from a write-back and when it supplies a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ads | input | 1 | Request strobe, one cycle per transaction |
| bus_addr | input | 33 | Request address bits 35 down to 3 |
| bus_kind | input | 3 | Transaction kind: 0 read line, 1 read partial, 2 write-back line, 3 write partial, 4 invalidate no data, 5 invalidate line |
| bus_agent | input | 2 | Requester id |
| snp_strobe | input | 1 | Snoop phase of the oldest transaction not yet snooped |
| snp_hitm | output | 1 | Modified-hit snoop response |
| bus_trdy | input | 1 | Target ready for the oldest transaction not yet answered |
| bus_drdy_in | input | 1 | A data beat driven by another agent or memory |
| bus_data_in | input | 64 | Data driven by another agent or memory |
| out_drdy | output | 1 | Data-ready for a beat supplied by this block |
| out_dbsy | output | 1 | Data-busy while this block owns the data bus |
| out_data | output | 64 | Beat supplied by this block |

## Verification
Pipelined pairs are the sharpest corner. If the hit lookup were deferred to the snoop cycle, a read issued right behind a write-back to the same line would miss. If the write-back data were captured too early, a read issued just before a displacing write-back would return the new line. If the queue pointers were swapped, the modified-hit response would land on the wrong transaction. The directed cases also cover a non-zero critical chunk, which exposes a plain linear beat order, and tag displacement on one index. They also cover both invalidate kinds, and the requester-id and partial filters, which a careless design would let fill or claim lines. Random sequences over a small pool of tags and indexes mix all of these patterns.

// File: rtl/victim_snoop_agent.sv
`timescale 1ns/1ps
module victim_snoop_agent #(
  parameter int CAP_BYTES = 1024,
  parameter int QDEPTH    = 4,
  parameter int AGENT_ID  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_ads,
  input  logic [35:3] bus_addr,
  input  logic [2:0]  bus_kind,
  input  logic [1:0]  bus_agent,
  input  logic        snp_strobe,
  output logic        snp_hitm,
  input  logic        bus_trdy,
  input  logic        bus_drdy_in,
  input  logic [63:0] bus_data_in,
  output logic        out_drdy,
  output logic        out_dbsy,
  output logic [63:0] out_data
);
  localparam int LINES = CAP_BYTES / 32;
  localparam int IW    = $clog2(LINES);
  localparam int TW    = 31 - IW;
  localparam int QW    = $clog2(QDEPTH);
  localparam logic [1:0] MY_ID = 2'(AGENT_ID);
  localparam logic [2:0] K_RDL = 3'd0, K_WBL = 3'd2, K_INV0 = 3'd4, K_INVL = 3'd5;

  logic [LINES-1:0] valid;
  logic [TW-1:0]    tags [LINES];
  logic [63:0]      mem  [LINES*4];

  logic          q_hit  [QDEPTH];
  logic          q_fill [QDEPTH];
  logic          q_line [QDEPTH];
  logic [1:0]    q_crit [QDEPTH];
  logic [IW-1:0] q_idx  [QDEPTH];

  logic [QW:0] wr_p, snp_p, hd_p;
  logic        busy;
  logic [1:0]  cnt;

  wire [QW-1:0] wr_i  = wr_p[QW-1:0];
  wire [QW-1:0] snp_i = snp_p[QW-1:0];
  wire [QW-1:0] hd_i  = hd_p[QW-1:0];

  wire          other   = bus_agent != MY_ID;
  wire [IW-1:0] a_idx   = bus_addr[IW+4:5];
  wire [TW-1:0] a_tag   = bus_addr[35:IW+5];
  wire [1:0]    a_crit  = bus_addr[4:3];
  wire          a_match = valid[a_idx] && (tags[a_idx] == a_tag);
  wire          a_inv   = (bus_kind == K_INV0) || (bus_kind == K_INVL);
  wire          a_linek = (bus_kind == K_RDL) || (bus_kind == K_WBL) || (bus_kind == K_INVL);
  wire          q_full  = (wr_p - hd_p) == (QW+1)'(QDEPTH);

  wire          serving = busy && q_hit[hd_i];
  wire          beat    = serving || bus_drdy_in;
  wire [1:0]    chunk   = cnt ^ q_crit[hd_i];
  wire [IW+1:0] m_addr  = {q_idx[hd_i], chunk};

  assign snp_hitm = snp_strobe && q_hit[snp_i];
  assign out_drdy = serving;
  assign out_dbsy = serving;
  assign out_data = serving ? mem[m_addr] : 64'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) valid <= '0;
    else if (bus_ads && other) begin
      if (bus_kind == K_WBL) valid[a_idx] <= 1'b1;
      else if (a_inv && a_match) valid[a_idx] <= 1'b0;
    end

  always_ff @(posedge clk)
    if (bus_ads && other && bus_kind == K_WBL) tags[a_idx] <= a_tag;

  always_ff @(posedge clk)
    if (busy && bus_drdy_in && q_fill[hd_i]) mem[m_addr] <= bus_data_in;

  always_ff @(posedge clk)
    if (bus_ads) begin
      q_hit[wr_i]  <= other && bus_kind == K_RDL && a_match;
      q_fill[wr_i] <= other && bus_kind == K_WBL;
      q_line[wr_i] <= a_linek;
      q_crit[wr_i] <= a_crit;
      q_idx[wr_i]  <= a_idx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_p <= '0; snp_p <= '0; hd_p <= '0; busy <= 1'b0; cnt <= 2'd0;
    end else begin
      if (bus_ads) wr_p <= wr_p + 1'b1;
      if (snp_strobe) snp_p <= snp_p + 1'b1;
      if (!busy && bus_trdy) begin
        if (q_line[hd_i]) begin busy <= 1'b1; cnt <= 2'd0; end
        else hd_p <= hd_p + 1'b1;
      end else if (busy && beat) begin
        if (cnt == 2'd3) begin busy <= 1'b0; hd_p <= hd_p + 1'b1; end
        cnt <= cnt + 2'd1;
      end
    end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads |-> !q_full);
  a_r8_snoop_pending: assert property (@(posedge clk) disable iff (!rst_n)
    snp_strobe |-> (snp_p != wr_p));
  a_r8_resp_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trdy |-> (!busy && hd_p != snp_p));
  a_r4_start_after_trdy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_drdy) |-> $past(bus_trdy));
  a_r4_four_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (out_drdy && cnt != 2'd3) |=> out_drdy);
  a_r4_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_drdy) |-> $past(cnt) == 2'd3);
  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    out_drdy |-> !bus_drdy_in);
  a_r2_wb_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ads && other && bus_kind == K_WBL) |=> valid[$past(a_idx)]);
  a_r6_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ads && other && a_inv) |=> !valid[$past(a_idx)] || $past(!a_match));
endmodule

// File: tb/test_victim_snoop_agent.sv
`timescale 1ns/1ps
module test_victim_snoop_agent;
  localparam int MYID = 1;
  logic clk = 0, rst_n = 0;
  logic bus_ads = 0, snp_strobe = 0, bus_trdy = 0, bus_drdy_in = 0;
  logic [35:3] bus_addr = '0;
  logic [2:0] bus_kind = '0;
  logic [1:0] bus_agent = '0;
  logic [63:0] bus_data_in = '0;
  logic snp_hitm, out_drdy, out_dbsy;
  logic [63:0] out_data;

  victim_snoop_agent #(.CAP_BYTES(1024), .QDEPTH(4), .AGENT_ID(MYID)) i_victim_snoop_agent (
    .clk(clk), .rst_n(rst_n), .bus_ads(bus_ads), .bus_addr(bus_addr), .bus_kind(bus_kind),
    .bus_agent(bus_agent), .snp_strobe(snp_strobe), .snp_hitm(snp_hitm), .bus_trdy(bus_trdy),
    .bus_drdy_in(bus_drdy_in), .bus_data_in(bus_data_in), .out_drdy(out_drdy),
    .out_dbsy(out_dbsy), .out_data(out_data));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  logic        ref_valid [32];
  logic [25:0] ref_tag   [32];
  logic [63:0] ref_data  [32][4];
  logic        p_hit  [2];
  logic        p_line [2];
  logic [63:0] p_data [2][4];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_line(logic [2:0] k);
    return k == 3'd0 || k == 3'd2 || k == 3'd5;
  endfunction

  task automatic issue(int s, logic [2:0] k, logic [25:0] tg, logic [4:0] ix, logic [1:0] cr, logic [1:0] ag);
    bit oth = ag != 2'(MYID);
    bit m = ref_valid[ix] && ref_tag[ix] == tg;
    bus_ads = 1; bus_addr = {tg, ix, cr}; bus_kind = k; bus_agent = ag;
    p_hit[s] = oth && k == 3'd0 && m;
    p_line[s] = is_line(k);
    for (int b = 0; b < 4; b++)
      p_data[s][b] = p_hit[s] ? ref_data[ix][b ^ int'(cr)] : {$urandom, $urandom};
    if (oth && k == 3'd2) begin
      ref_valid[ix] = 1; ref_tag[ix] = tg;
      for (int b = 0; b < 4; b++) ref_data[ix][b ^ int'(cr)] = p_data[s][b];
    end else if (oth && (k == 3'd4 || k == 3'd5) && m) ref_valid[ix] = 0;
    @(negedge clk);
    bus_ads = 0;
  endtask

  task automatic snoop(int s);
    snp_strobe = 1;
    #1 chk(snp_hitm == p_hit[s], "R3/R5/R6/R7 snoop response", 64'(snp_hitm), 64'(p_hit[s]));
    @(negedge clk);
    snp_strobe = 0;
  endtask

  task automatic respond(int s);
    bus_trdy = 1;
    #1 chk(!out_drdy, "R4 no beat in target-ready cycle", 64'(out_drdy), 64'd0);
    @(negedge clk);
    bus_trdy = 0;
    if (p_line[s]) begin
      for (int b = 0; b < 4; b++) begin
        if (p_hit[s]) begin
          #1 chk(out_drdy && out_dbsy, "R4 drdy/dbsy on beat", 64'({out_drdy, out_dbsy}), 64'd3);
          chk(out_data == p_data[s][b], "R10/R8 supplied beat", out_data, p_data[s][b]);
        end else begin
          bus_drdy_in = 1; bus_data_in = p_data[s][b];
          #1 chk(!out_drdy && !out_dbsy, "R5 no drive on miss", 64'(out_drdy), 64'd0);
        end
        @(negedge clk);
      end
      bus_drdy_in = 0;
      #1 chk(!out_drdy && !out_dbsy, "R4 release after four beats", 64'(out_drdy), 64'd0);
    end
  endtask

  task automatic one(logic [2:0] k, logic [25:0] tg, logic [4:0] ix, logic [1:0] cr, logic [1:0] ag);
    issue(0, k, tg, ix, cr, ag); snoop(0); respond(0);
  endtask

  task automatic pair(logic [2:0] k0, logic [25:0] t0, logic [4:0] i0, logic [1:0] c0,
                      logic [2:0] k1, logic [25:0] t1, logic [4:0] i1, logic [1:0] c1);
    issue(0, k0, t0, i0, c0, 2'd0); issue(1, k1, t1, i1, c1, 2'd2);
    snoop(0); snoop(1); respond(0); respond(1);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) ref_valid[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk(!snp_hitm && !out_drdy && !out_dbsy, "R1 outputs idle after reset", 64'({snp_hitm, out_drdy, out_dbsy}), 64'd0);
    one(3'd0, 26'h5, 5'd3, 2'd0, 2'd0);                 // R1 first read misses
    one(3'd2, 26'h5, 5'd3, 2'd0, 2'd0);                 // R2 fill
    one(3'd0, 26'h5, 5'd3, 2'd0, 2'd2);                 // R3 R4 hit
    one(3'd0, 26'h5, 5'd3, 2'd2, 2'd0);                 // R10 critical chunk 2
    one(3'd2, 26'h7, 5'd9, 2'd3, 2'd2);                 // R10 fill with chunk 3 first
    one(3'd0, 26'h7, 5'd9, 2'd1, 2'd0);
    one(3'd0, 26'h6, 5'd3, 2'd0, 2'd0);                 // R9 other tag misses
    one(3'd2, 26'h6, 5'd3, 2'd1, 2'd0);                 // R9 displacement
    one(3'd0, 26'h5, 5'd3, 2'd0, 2'd0);
    one(3'd0, 26'h6, 5'd3, 2'd0, 2'd0);
    one(3'd4, 26'h6, 5'd3, 2'd0, 2'd0);                 // R6 zero-byte invalidate
    one(3'd0, 26'h6, 5'd3, 2'd0, 2'd0);
    one(3'd5, 26'h7, 5'd9, 2'd0, 2'd0);                 // R6 full-line invalidate
    one(3'd0, 26'h7, 5'd9, 2'd0, 2'd0);
    one(3'd2, 26'h8, 5'd4, 2'd0, 2'(MYID));             // R7 own write-back ignored
    one(3'd0, 26'h8, 5'd4, 2'd0, 2'd0);
    one(3'd2, 26'h9, 5'd5, 2'd0, 2'd0);
    one(3'd0, 26'h9, 5'd5, 2'd0, 2'(MYID));             // R7 own read not claimed
    one(3'd1, 26'h9, 5'd5, 2'd0, 2'd0);                 // R7 partial read
    one(3'd3, 26'h9, 5'd5, 2'd0, 2'd0);                 // R7 partial write
    one(3'd4, 26'h9, 5'd5, 2'd0, 2'(MYID));             // R7 own invalidate
    one(3'd0, 26'h9, 5'd5, 2'd0, 2'd2);
    pair(3'd2, 26'hA, 5'd6, 2'd0, 3'd0, 26'hA, 5'd6, 2'd1);   // R8 read behind write-back
    pair(3'd0, 26'hA, 5'd6, 2'd0, 3'd2, 26'hB, 5'd6, 2'd0);   // R8 read ahead of displacement
    pair(3'd0, 26'hB, 5'd6, 2'd3, 3'd0, 26'hC, 5'd6, 2'd0);   // R8 hit then miss pairing
    for (int it = 0; it < 400; it++) begin
      int n = int'($urandom % 2) + 1;
      for (int s = 0; s < n; s++)
        issue(s, 3'($urandom % 6), 26'(($urandom % 3) + 1), 5'(($urandom % 4) * 7),
              2'($urandom % 4), ($urandom % 4 == 0) ? 2'(MYID) : 2'(($urandom % 2) * 2));
      for (int s = 0; s < n; s++) snoop(s);
      for (int s = 0; s < n; s++) respond(s);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule